// File: doc/BRIEF.md
# Interlocked Read Handshake Memory Responder

This block is the memory end of a clockless, fully interlocked read handshake on a shared address/data bus. A requester puts a word address on the bus and raises its request line. The responder captures the address and answers with an acknowledge. It then waits for the requester to withdraw the request, and it drops the acknowledge to confirm the release. Once the word has been read from a small internal array, the responder drives the word onto the bus and raises a data-ready strobe. It keeps the word on the bus until the requester raises its own acknowledge. It then drops the strobe and releases the bus.

The responder runs in its own clock domain. Both incoming handshake lines pass through two-flop synchronizers before any decision uses them. The bus is modelled as a separate input value, output value and output enable, with no tristate pad. The array read starts on the edge that captures the address. It therefore overlaps the acknowledge, release and acknowledge-drop steps, and data is offered after whichever of the two paths finishes last.

Inside the block, the array read path hands its word to the handshake controller over a valid/ready pair. The controller is ready only once the release steps are complete, and the read path holds the word and valid until it is taken. At the bus, the requester's acknowledge plays the part of ready: the word is held unchanged for as long as that acknowledge stays low.

Top module: `hs_mem_responder`

## Requirements
- R1: During and after reset, `ack_o`, `data_rdy_o` and `bus_oe_o` are low.
- R2: In idle, once the synchronized request is high and the synchronized requester acknowledge is low, the block latches the word address from `bus_i[ADDR_W-1:0]` (upper bus bits ignored) and raises `ack_o`.
- R3: While `ack_o` is high, `ack_o` falls only after the synchronized request has been seen low.
- R4: When `data_rdy_o` rises, `bus_o` carries the array word at the latched address, and `bus_o` holds that value for as long as `data_rdy_o` is high. The word at address A is `(A * 32'h9E3779B9) ^ 32'h5A5AC3C3`, truncated to `DATA_W`.
- R5: While `data_rdy_o` is high, seeing the synchronized requester acknowledge high makes `data_rdy_o` and `bus_oe_o` fall on the same edge.
- R6: `data_rdy_o` rises no earlier than `ACCESS_LAT` clock edges after the rising edge of `ack_o` in the same transfer, and never while `ack_o` is high.
- R7: While the requester's acknowledge is still high, a new request is not answered: `ack_o` stays low.
- R8: `bus_oe_o` is high only while `data_rdy_o` is high.
- R9: A request raised just after an edge shows on `ack_o` after exactly three rising edges: two synchronizer stages and one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| read_req_i | input | 1 | Requester's read strobe (asynchronous) |
| ack_i | input | 1 | Requester's acknowledge of data-ready (asynchronous) |
| bus_i | input | DATA_W | Value seen on the shared address/data lines |
| ack_o | output | 1 | Responder's acknowledge of the read strobe |
| data_rdy_o | output | 1 | Read word is valid on the bus |
| bus_o | output | DATA_W | Value driven onto the shared lines |
| bus_oe_o | output | 1 | Output enable for `bus_o` |

## Verification
The assertions assume the requester obeys the interlock. It holds the address steady on `bus_i` while its request is high. It withdraws the request only after seeing `ack_o`. It raises its acknowledge only after seeing `data_rdy_o`, and it keeps that acknowledge high until `data_rdy_o` has fallen. The bench acts as such a requester. It changes its inputs only on falling clock edges and always waits for the responder's edge before taking its next step. Inside those rules it uses random addresses, random upper bus bits, random release delays and random data-hold times, and it fills the released bus with junk to show that the latched address is used.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACKED,
    ST_WAIT_DATA,
    ST_DRIVE
  } hs_state_t;

  function automatic logic [31:0] array_word(input logic [31:0] idx);
    return (idx * 32'h9E3779B9) ^ 32'h5A5AC3C3;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;

endmodule

// File: rtl/hs_array_read.sv
module hs_array_read
  import hs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int ACCESS_LAT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(ACCESS_LAT + 1);

  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    logic [31:0] full_word;
    assign full_word = array_word(32'(i));
    assign rom[i]    = DATA_W'(full_word);
  end

  logic             busy;
  logic [CNT_W-1:0] remain;
  logic [DATA_W-1:0] word_q;

  assign valid_o = busy && (remain == '0);
  assign data_o  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      word_q <= '0;
    end else if (start_i) begin
      busy   <= 1'b1;
      remain <= CNT_W'(ACCESS_LAT - 1);
      word_q <= rom[addr_i];
    end else if (busy) begin
      if (valid_o && ready_i)
        busy <= 1'b0;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/hs_mem_responder.sv
module hs_mem_responder
  import hs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int STEP_CYC   = 3,
  parameter int ACCESS_LAT = 5 * STEP_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic              data_rdy_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);

  logic req_s, ack_s;
  logic [1:0] sync_out;

  hs_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({read_req_i, ack_i}),
    .q_o   (sync_out)
  );
  assign req_s = sync_out[1];
  assign ack_s = sync_out[0];

  logic unused_bus_hi;
  assign unused_bus_hi = ^bus_i[DATA_W-1:ADDR_W];

  hs_state_t         state;
  logic              ack_q, rdy_q, oe_q;
  logic [DATA_W-1:0] drive_q;
  logic              accept, rd_valid, rd_ready;
  logic [DATA_W-1:0] rd_data;

  assign accept   = (state == ST_IDLE) && req_s && !ack_s;
  assign rd_ready = (state == ST_WAIT_DATA);

  hs_array_read #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .ACCESS_LAT (ACCESS_LAT)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .addr_i  (bus_i[ADDR_W-1:0]),
    .valid_o (rd_valid),
    .ready_i (rd_ready),
    .data_o  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ack_q   <= 1'b0;
      rdy_q   <= 1'b0;
      oe_q    <= 1'b0;
      drive_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ack_q <= 1'b1;
            state <= ST_ACKED;
          end
        end
        ST_ACKED: begin
          if (!req_s) begin
            ack_q <= 1'b0;
            state <= ST_WAIT_DATA;
          end
        end
        ST_WAIT_DATA: begin
          if (rd_valid) begin
            drive_q <= rd_data;
            rdy_q   <= 1'b1;
            oe_q    <= 1'b1;
            state   <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (ack_s) begin
            rdy_q   <= 1'b0;
            oe_q    <= 1'b0;
            drive_q <= '0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ack_o      = ack_q;
  assign data_rdy_o = rdy_q;
  assign bus_oe_o   = oe_q;
  assign bus_o      = drive_q;

endmodule

// File: rtl/hs_mem_responder_chk.sv
module hs_mem_responder_chk #(
  parameter int DATA_W     = 32,
  parameter int ACCESS_LAT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_s,
  input logic              ack_s,
  input logic              ack_o,
  input logic              data_rdy_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] bus_o
);

  localparam int CW = $clog2(ACCESS_LAT + 2);

  logic          ack_prev;
  logic [CW-1:0] since_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev  <= 1'b0;
      since_ack <= '0;
    end else begin
      ack_prev <= ack_o;
      if (ack_o && !ack_prev)
        since_ack <= CW'(1);
      else if (since_ack != '0 && since_ack < CW'(ACCESS_LAT))
        since_ack <= since_ack + 1'b1;
    end
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!ack_o && !data_rdy_o && !bus_oe_o);
    end
  end

  assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s));

  assert_ack_drop_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s));

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rdy_o && $past(data_rdy_o)) |-> $stable(bus_o));

  assert_rdy_drop_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy_o) |-> ($past(ack_s) && !bus_oe_o));

  assert_latency_met_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy_o) |-> (since_ack >= CW'(ACCESS_LAT) && !ack_o));

  assert_no_accept_while_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> !$past(ack_s));

  assert_oe_only_with_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> data_rdy_o);

endmodule

bind hs_mem_responder hs_mem_responder_chk #(
  .DATA_W     (DATA_W),
  .ACCESS_LAT (ACCESS_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_s      (req_s),
  .ack_s      (ack_s),
  .ack_o      (ack_o),
  .data_rdy_o (data_rdy_o),
  .bus_oe_o   (bus_oe_o),
  .bus_o      (bus_o)
);

// File: tb/hs_mem_responder_bench.sv
module hs_mem_responder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int LAT        = 15;
  localparam int WAIT_LIM   = 500;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              read_req_i = 1'b0;
  logic              ack_i = 1'b0;
  logic [DATA_W-1:0] bus_i = '0;
  logic              ack_o, data_rdy_o, bus_oe_o;
  logic [DATA_W-1:0] bus_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_mem_responder #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .STEP_CYC (3), .ACCESS_LAT (LAT)
  ) u_hs_mem_responder (
    .clk (clk), .rst_n (rst_n), .read_req_i (read_req_i), .ack_i (ack_i),
    .bus_i (bus_i), .ack_o (ack_o), .data_rdy_o (data_rdy_o),
    .bus_o (bus_o), .bus_oe_o (bus_oe_o)
  );

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a);
    logic [31:0] a32;
    a32 = 32'(a);
    return (a32 * 32'h9E3779B9) ^ 32'h5A5AC3C3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One read transfer, acting as an interlock-obeying requester.
  task automatic do_read(input logic [ADDR_W-1:0] a, input int hold,
                         input int data_hold, input bit keep_ack, input bit chk_sync);
    int n;
    int t_ack, t_rdy;
    bus_i = ($urandom() & ~32'(2**ADDR_W - 1)) | 32'(a);
    read_req_i = 1'b1;
    if (ack_i) begin
      repeat (12) begin
        step();
        check(!ack_o, "R7 no ack while requester ack high", 32'(ack_o), 0);
      end
      ack_i = 1'b0;
    end
    n = 0;
    do begin step(); n++; end while (!ack_o && n < WAIT_LIM);
    t_ack = cyc;
    check(ack_o, "R2 ack raised on request", 32'(ack_o), 1);
    if (chk_sync) check(n == 3, "R9 request to ack edges", 32'(n), 3);
    repeat (hold) begin
      step();
      check(ack_o, "R3 ack held while request high", 32'(ack_o), 1);
    end
    read_req_i = 1'b0;
    bus_i = $urandom();
    n = 0;
    do begin step(); n++; end while (ack_o && n < WAIT_LIM);
    check(!ack_o, "R3 ack dropped after release", 32'(ack_o), 0);
    n = 0;
    while (!data_rdy_o && n < WAIT_LIM) begin
      check(!bus_oe_o, "R8 no drive before data ready", 32'(bus_oe_o), 0);
      step(); n++;
    end
    t_rdy = cyc;
    check(data_rdy_o, "R4 data ready raised", 32'(data_rdy_o), 1);
    check(bus_o == exp_word(a), "R4 word on bus", bus_o, exp_word(a));
    check(bus_oe_o, "R8 drive with data ready", 32'(bus_oe_o), 1);
    check(!ack_o, "R6 ack low at data ready", 32'(ack_o), 0);
    check(t_rdy - t_ack >= LAT, "R6 latency from ack", 32'(t_rdy - t_ack), 32'(LAT));
    repeat (data_hold) step();
    check(data_rdy_o && bus_o == exp_word(a), "R4 word held until ack", bus_o, exp_word(a));
    ack_i = 1'b1;
    n = 0;
    do begin step(); n++; end while (data_rdy_o && n < WAIT_LIM);
    check(!data_rdy_o, "R5 data ready dropped", 32'(data_rdy_o), 0);
    check(!bus_oe_o, "R5 drive dropped with data ready", 32'(bus_oe_o), 0);
    check(n == 3, "R5 ack to release edges", 32'(n), 3);
    if (!keep_ack) begin
      ack_i = 1'b0;
      repeat (2) step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    repeat (3) step();
    check(!ack_o && !data_rdy_o && !bus_oe_o, "R1 outputs low in reset",
          {29'd0, ack_o, data_rdy_o, bus_oe_o}, 0);
    rst_n = 1'b1;
    repeat (3) step();
    check(!ack_o && !data_rdy_o && !bus_oe_o, "R1 outputs low after reset",
          {29'd0, ack_o, data_rdy_o, bus_oe_o}, 0);

    process::self().srandom(32'd20240611);

    // Directed corners: lowest and highest address, fast release,
    // release later than the array latency, and a request held off by ack.
    do_read('0, 0, 0, 1'b0, 1'b1);
    do_read({ADDR_W{1'b1}}, 30, 4, 1'b0, 1'b1);
    do_read(4'h5, 2, 1, 1'b1, 1'b1);
    do_read(4'hA, 1, 2, 1'b0, 1'b0);

    // Constrained random transfers.
    for (int i = 0; i < 40; i++) begin
      do_read(ADDR_W'($urandom()), int'($urandom_range(0, 25)),
              int'($urandom_range(0, 6)), ($urandom_range(0, 4) == 0), 1'b1);
    end
    ack_i = 1'b0;
    repeat (5) step();
    check(!ack_o && !data_rdy_o && !bus_oe_o, "R8 idle bus released",
          {29'd0, ack_o, data_rdy_o, bus_oe_o}, 0);
    done = 1'b1;
    report();
  end

endmodule